// File: doc/BRIEF.md
# BCD Seven-Segment Digit Decoder with Zero Suppression Chain

This block turns one 4-bit binary-coded-decimal digit into seven active-high segment drives, a through g. It also has two control inputs. The first is a digit enable, `show_i`. The second is an active-low suppress-carry input, `sup_n_i`. Together they choose one of four things: a lamp test, a forced blank, the normal digit, or a blanked non-significant zero. A suppress-carry output, `sup_n_o`, goes low only when this digit is a blanked zero or is in lamp test. Wiring that output to the `sup_n_i` of the next less significant digit makes leading zeros vanish one digit after another.

The decoding is purely combinational. An optional output register, selected by the parameter `OUT_REG` and on by default, puts both the segments and the carry output behind one flop stage for timing closure. When the register is present, every output shows the inputs of the previous clock edge. Reset drives all segments dark and the carry output high.

Top module: `seg_digit_decoder`

## Requirements
- R1: With `show_i`=1, codes 1 to 8 light their usual decimal glyphs whatever `sup_n_i` is, and `sup_n_o` is 1. Code 0 with `sup_n_i`=1 lights a, b, c, d, e and f, and `sup_n_o` is 1. The segment bus is `seg_o[6:0]` = {g,f,e,d,c,b,a}, and 1 means lit.
- R2: The digit 9 lights a, b, c, f and g with d dark (`seg_o`=7'h67). The digit 6 lights its top segment a (7'h7D). The digit 7 lights only a, b and c (7'h07).
- R3: With `show_i`=1, codes 10 to 15 give `seg_o`=0 and `sup_n_o`=1, whatever `sup_n_i` is.
- R4: With `show_i`=0 and `sup_n_i`=0, all seven segments are lit (`seg_o`=7'h7F) and `sup_n_o` is 0, for any code.
- R5: With `show_i`=0 and `sup_n_i`=1, `seg_o`=0 and `sup_n_o`=1, for any code.
- R6: With `show_i`=1, `sup_n_i`=0 and code 0, `seg_o`=0 and `sup_n_o`=0.
- R7: With `OUT_REG`=1, the outputs are the decode of the inputs sampled at the previous rising clock edge. While `rst_ni` is low, `seg_o`=0 and `sup_n_o`=1.
- R8: Whenever `sup_n_o` is 0, `seg_o` is either all dark or all lit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous reset, active low |
| show_i | input | 1 | Digit enable; 0 selects lamp test or forced blank |
| sup_n_i | input | 1 | Suppress-carry input, active low |
| bcd_i | input | 4 | BCD digit code |
| seg_o | output | 7 | Segment drives {g,f,e,d,c,b,a}, active high |
| sup_n_o | output | 1 | Suppress-carry output for the next digit, active low |

## Verification
Two functions can coincide in one cycle. The first pair is lamp test and zero suppression: both are asked for by a low `sup_n_i`, and only the enable decides which one wins. The second pair is illegal-code blanking and either lamp test or forced blank. The bench drives every one of the 64 combinations of enable, suppress input and code, back to back with no idle cycles. That includes code 0 and codes 10 to 15 under a low enable, where two rules compete for the outputs. Each result is compared every clock against a behavioural model. The model applies the precedence of the requirements: enable first, then code legality, then zero suppression.

// File: rtl/seg_dec_pkg.sv
package seg_dec_pkg;

   // Operating mode chosen by the enable / suppress pair
   typedef enum logic [1:0] {
      MODE_LAMP  = 2'd0,
      MODE_BLANK = 2'd1,
      MODE_SHOW  = 2'd2
   } seg_mode_t;

   localparam int unsigned BCD_W     = 4;
   localparam int unsigned SEGS      = 7;
   localparam int unsigned MAX_DIGIT = 9;

endpackage

// File: rtl/seg_glyph_enc.sv
module seg_glyph_enc #(
   parameter int unsigned DIGIT_W = 4,
   parameter int unsigned SEG_W   = 7
) (
   input  logic [DIGIT_W-1:0] code_i,
   output logic [SEG_W-1:0]   glyph_o,
   output logic               legal_o,
   output logic               zero_o
);
   import seg_dec_pkg::*;

   localparam logic [DIGIT_W-1:0] LAST = DIGIT_W'(MAX_DIGIT);

   if (DIGIT_W != BCD_W) begin : g_bad_digit_w
      $error("seg_glyph_enc: DIGIT_W must be 4");
   end
   if (SEG_W != SEGS) begin : g_bad_seg_w
      $error("seg_glyph_enc: SEG_W must be 7");
   end

   logic [SEGS-1:0] raw;

   // bit order {g,f,e,d,c,b,a}
   always_comb begin
      unique case (code_i)
         DIGIT_W'(0): raw = 7'b011_1111;
         DIGIT_W'(1): raw = 7'b000_0110;
         DIGIT_W'(2): raw = 7'b101_1011;
         DIGIT_W'(3): raw = 7'b100_1111;
         DIGIT_W'(4): raw = 7'b110_0110;
         DIGIT_W'(5): raw = 7'b110_1101;
         DIGIT_W'(6): raw = 7'b111_1101;
         DIGIT_W'(7): raw = 7'b000_0111;
         DIGIT_W'(8): raw = 7'b111_1111;
         DIGIT_W'(9): raw = 7'b110_0111;
         default:     raw = '0;
      endcase
   end

   assign legal_o = (code_i <= LAST);
   assign zero_o  = (code_i == '0);
   assign glyph_o = legal_o ? SEG_W'(raw) : '0;

endmodule

// File: rtl/seg_mode_sel.sv
module seg_mode_sel (
   input  logic                   show_i,
   input  logic                   sup_n_i,
   input  logic                   zero_i,
   output seg_dec_pkg::seg_mode_t mode_o,
   output logic                   sup_n_o
);
   import seg_dec_pkg::*;

   always_comb begin
      mode_o  = MODE_SHOW;
      sup_n_o = 1'b1;
      if (!show_i) begin
         if (!sup_n_i) begin
            mode_o  = MODE_LAMP;
            sup_n_o = 1'b0;
         end else begin
            mode_o  = MODE_BLANK;
         end
      end else if (zero_i && !sup_n_i) begin
         mode_o  = MODE_BLANK;
         sup_n_o = 1'b0;
      end
   end

endmodule

// File: rtl/seg_out_stage.sv
module seg_out_stage #(
   parameter int unsigned W          = 8,
   parameter bit          REGISTERED = 1'b1,
   parameter logic [W-1:0] RST_VAL   = '0
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (REGISTERED) begin : g_reg
      logic [W-1:0] q_r;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) q_r <= RST_VAL;
         else         q_r <= d_i;
      end
      assign q_o = q_r;
   end else begin : g_bypass
      assign q_o = d_i;
   end

endmodule

// File: rtl/seg_digit_decoder.sv
module seg_digit_decoder #(
   parameter int unsigned DIGIT_W = 4,
   parameter int unsigned SEG_W   = 7,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               show_i,
   input  logic               sup_n_i,
   input  logic [DIGIT_W-1:0] bcd_i,
   output logic [SEG_W-1:0]   seg_o,
   output logic               sup_n_o
);
   import seg_dec_pkg::*;

   localparam int unsigned OUT_W = SEG_W + 1;
   localparam logic [OUT_W-1:0] OUT_RST = {1'b1, {SEG_W{1'b0}}};

   if (DIGIT_W != BCD_W) begin : g_bad_digit_w
      $error("seg_digit_decoder: DIGIT_W must be 4");
   end
   if (SEG_W != SEGS) begin : g_bad_seg_w
      $error("seg_digit_decoder: SEG_W must be 7");
   end

   logic [SEG_W-1:0] glyph;
   logic             legal;
   logic             is_zero;
   seg_mode_t        mode;
   logic             sup_n_c;
   logic [SEG_W-1:0] seg_c;
   logic [OUT_W-1:0] out_q;

   seg_glyph_enc #(
      .DIGIT_W (DIGIT_W),
      .SEG_W   (SEG_W)
   ) u_glyph (
      .code_i  (bcd_i),
      .glyph_o (glyph),
      .legal_o (legal),
      .zero_o  (is_zero)
   );

   seg_mode_sel u_mode (
      .show_i  (show_i),
      .sup_n_i (sup_n_i),
      .zero_i  (is_zero),
      .mode_o  (mode),
      .sup_n_o (sup_n_c)
   );

   always_comb begin
      unique case (mode)
         MODE_LAMP:  seg_c = '1;
         MODE_BLANK: seg_c = '0;
         default:    seg_c = legal ? glyph : '0;
      endcase
   end

   seg_out_stage #(
      .W          (OUT_W),
      .REGISTERED (OUT_REG),
      .RST_VAL    (OUT_RST)
   ) u_out (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    ({sup_n_c, seg_c}),
      .q_o    (out_q)
   );

   assign seg_o   = out_q[SEG_W-1:0];
   assign sup_n_o = out_q[SEG_W];

endmodule

// File: rtl/seg_dec_chk.sv
module seg_dec_chk #(
   parameter int unsigned DIGIT_W = 4,
   parameter int unsigned SEG_W   = 7,
   parameter bit          OUT_REG = 1'b1
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               show_i,
   input logic               sup_n_i,
   input logic [DIGIT_W-1:0] bcd_i,
   input logic [SEG_W-1:0]   seg_o,
   input logic               sup_n_o
);

   logic               obs_ok;
   logic               obs_show;
   logic               obs_sup;
   logic [DIGIT_W-1:0] obs_code;

   if (OUT_REG) begin : g_delay
      logic               ok_r, show_r, sup_r;
      logic [DIGIT_W-1:0] code_r;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            ok_r   <= 1'b0;
            show_r <= 1'b1;
            sup_r  <= 1'b1;
            code_r <= '0;
         end else begin
            ok_r   <= 1'b1;
            show_r <= show_i;
            sup_r  <= sup_n_i;
            code_r <= bcd_i;
         end
      end
      assign obs_ok   = ok_r;
      assign obs_show = show_r;
      assign obs_sup  = sup_r;
      assign obs_code = code_r;
   end else begin : g_live
      assign obs_ok   = 1'b1;
      assign obs_show = show_i;
      assign obs_sup  = sup_n_i;
      assign obs_code = bcd_i;
   end

   p_lamp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (obs_ok && !obs_show && !obs_sup) |-> (seg_o == '1 && !sup_n_o));

   p_force_blank_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (obs_ok && !obs_show && obs_sup) |-> (seg_o == '0 && sup_n_o));

   p_zero_sup_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (obs_ok && obs_show && !obs_sup && obs_code == '0) |-> (seg_o == '0 && !sup_n_o));

   p_illegal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (obs_ok && obs_show && obs_code > DIGIT_W'(9)) |-> (seg_o == '0 && sup_n_o));

   p_nine_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (obs_ok && obs_show && obs_code == DIGIT_W'(9)) |-> (seg_o == SEG_W'(7'h67)));

   p_nonzero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (obs_ok && obs_show && obs_code != '0 && obs_code <= DIGIT_W'(9)) |-> (sup_n_o && seg_o != '0));

   p_carry_shape_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sup_n_o) |-> (seg_o == '0 || seg_o == '1));

endmodule

bind seg_digit_decoder seg_dec_chk #(
   .DIGIT_W (DIGIT_W),
   .SEG_W   (SEG_W),
   .OUT_REG (OUT_REG)
) u_seg_dec_chk (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .show_i  (show_i),
   .sup_n_i (sup_n_i),
   .bcd_i   (bcd_i),
   .seg_o   (seg_o),
   .sup_n_o (sup_n_o)
);

// File: tb/tb_seg_digit_decoder.sv
`timescale 1ns/1ps
module tb_seg_digit_decoder;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       show = 1'b1;
   logic       sup_n = 1'b1;
   logic [3:0] bcd = '0;
   logic [6:0] seg;
   logic       sup_out;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit run_cmp = 1'b0;
   bit done = 1'b0;

   logic [6:0] exp_seg = '0;
   logic       exp_sup = 1'b1;
   string      exp_req = "R7";

   always #2.5 clk = ~clk;

   seg_digit_decoder dut (
      .clk_i   (clk),
      .rst_ni  (rst_n),
      .show_i  (show),
      .sup_n_i (sup_n),
      .bcd_i   (bcd),
      .seg_o   (seg),
      .sup_n_o (sup_out)
   );

   // behavioural glyph: one membership list per segment
   function automatic logic [6:0] glyph_of(int d);
      logic [6:0] s;
      s[0] = d inside {0, 2, 3, 5, 6, 7, 8, 9};
      s[1] = d inside {0, 1, 2, 3, 4, 7, 8, 9};
      s[2] = d inside {0, 1, 3, 4, 5, 6, 7, 8, 9};
      s[3] = d inside {0, 2, 3, 5, 6, 8};
      s[4] = d inside {0, 2, 6, 8};
      s[5] = d inside {0, 4, 5, 6, 8, 9};
      s[6] = d inside {2, 3, 4, 5, 6, 8, 9};
      return s;
   endfunction

   function automatic string req_of(bit en, bit sn, int d);
      if (!en) return sn ? "R5" : "R4";
      if (d > 9) return "R3";
      if (d == 0) return sn ? "R1" : "R6";
      if (d == 6 || d == 7 || d == 9) return "R2";
      return "R1";
   endfunction

   task automatic check(string req, logic [6:0] s_act, logic [6:0] s_exp,
                        logic c_act, logic c_exp);
      checks++;
      if (s_act !== s_exp || c_act !== c_exp) begin
         fails++;
         $display("FAIL %s: seg=%h carry=%b expected seg=%h carry=%b",
                  req, s_act, c_act, s_exp, c_exp);
      end
   endtask

   // reference model, one register stage like the default output option (R7)
   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (!rst_n) begin
         exp_seg <= '0;
         exp_sup <= 1'b1;
         exp_req <= "R7";
      end else begin
         exp_req <= req_of(show, sup_n, int'(bcd));
         if (!show) begin
            exp_seg <= sup_n ? 7'h00 : 7'h7F;
            exp_sup <= sup_n;
         end else if (bcd > 4'd9) begin
            exp_seg <= '0;
            exp_sup <= 1'b1;
         end else if (bcd == 4'd0 && !sup_n) begin
            exp_seg <= '0;
            exp_sup <= 1'b0;
         end else begin
            exp_seg <= glyph_of(int'(bcd));
            exp_sup <= 1'b1;
         end
      end
   end

   always @(negedge clk) begin
      if (run_cmp && !done) begin
         check(exp_req, seg, exp_seg, sup_out, exp_sup);
         if (sup_out === 1'b0 && seg !== 7'h00 && seg !== 7'h7F) begin
            fails++;
            $display("FAIL R8: seg=%h carry=0 expected all dark or all lit", seg);
         end
         checks++;
      end
   end

   always @(posedge clk) begin
      if (cycles > 20000 && !done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog: cycles=%0d expected below 20000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   task automatic apply(bit en, bit sn, int d);
      show  = en;
      sup_n = sn;
      bcd   = 4'(d);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R7: reset state, with inputs that would otherwise light segments
      show = 1'b0; sup_n = 1'b0; bcd = 4'd8;
      @(negedge clk);
      check("R7", seg, 7'h00, sup_out, 1'b1);
      show = 1'b1; sup_n = 1'b1;
      @(negedge clk);
      rst_n = 1'b1;
      run_cmp = 1'b1;
      @(negedge clk);
      // exhaustive 64 combinations, back to back
      for (int en = 0; en < 2; en++)
         for (int sn = 0; sn < 2; sn++)
            for (int d = 0; d < 16; d++)
               apply(en[0], sn[0], d);
      // reversed order: lamp test, blank, suppression interleaved with digits
      for (int i = 63; i >= 0; i--)
         apply(i[5], i[4], i[3:0]);
      // R7 latency: inputs changed at a falling edge must not reach outputs yet
      apply(1'b1, 1'b1, 3);
      show = 1'b0; sup_n = 1'b0; bcd = 4'd0;
      #1;
      check("R7", seg, 7'h4F, sup_out, 1'b1);
      @(negedge clk);
      // direct spot checks of named glyphs
      apply(1'b1, 1'b0, 9);
      check("R2", seg, 7'h67, sup_out, 1'b1);
      apply(1'b1, 1'b0, 6);
      check("R2", seg, 7'h7D, sup_out, 1'b1);
      apply(1'b1, 1'b1, 0);
      check("R1", seg, 7'h3F, sup_out, 1'b1);
      apply(1'b1, 1'b0, 0);
      check("R6", seg, 7'h00, sup_out, 1'b0);
      apply(1'b0, 1'b0, 13);
      check("R4", seg, 7'h7F, sup_out, 1'b0);
      apply(1'b0, 1'b1, 5);
      check("R5", seg, 7'h00, sup_out, 1'b1);
      apply(1'b1, 1'b0, 12);
      check("R3", seg, 7'h00, sup_out, 1'b1);
      run_cmp = 1'b0;
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule